// File: doc/BRIEF.md
# GPIO Port Register Bank

This block is the register and pin-control core of an 8-bit general-purpose I/O port. It holds four byte-wide registers, each picked by a 2-bit index. The first holds the sampled pin levels and can only be read. The second holds the levels to drive, the third holds per-bit read inversion and the fourth sets each pin's direction. A host reaches the registers through a write strobe and a read strobe that share the index. The serial-bus front end that would normally issue these strobes is not part of this block.

Each pad is modelled as three separate signals: an incoming level, an outgoing value and an output enable. Incoming levels pass through a two-stage synchronizer. A read returns a registered snapshot one cycle after the strobe, so one bus byte always sees a stable value. Bit 0 can only pull low. Bits 1 to 7 drive both levels. The active-low reset is sampled on the clock edge and holds every register at its default while it is low.

The strobes are plain control signals. The block accepts a strobe in every cycle and has no back-pressure. A read result is marked by a one-cycle valid pulse and stays on the read-data port until the next read.

Top module: `gpio_port_regs`

## Requirements
- R1: Index 1 selects the output register, index 2 the inversion register and index 3 the direction register. A write with `wr_en` high stores `wr_data` in the selected register, and a later read of that index returns the stored byte.
- R2: A write to index 0 changes no register. Reads of indices 1 to 3 and the `pin_oe`/`pin_out` ports are the same before and after such a write.
- R3: A read of index 0 returns the pin levels as they were two clock edges before the read strobe's edge, XORed with the inversion register. This holds whether a pin is set as input or output.
- R4: A read of index 1 returns the stored output byte, not the level seen on `pin_in`.
- R5: An inversion bit of 1 flips the matching bit of the index-0 read value. An inversion bit of 0 leaves it as it is.
- R6: For bits 1 to 7, direction bit 1 gives `pin_oe` 0 (input, driver off). Direction bit 0 gives `pin_oe` 1, and `pin_out` then equals the output register bit.
- R7: Bit 0 is open-drain. `pin_out[0]` is always 0, and `pin_oe[0]` is 1 only when direction bit 0 is 0 and output bit 0 is 0.
- R8: After reset the output register reads 0x00, the inversion register reads 0xF0, the direction register reads 0xFF and `pin_oe` is 0x00.
- R9: While `rst_n` is low, all registers stay at their defaults and writes are ignored. Normal writes resume after release.
- R10: A read strobe in one cycle makes `rd_valid` high for exactly the next cycle, with the result on `rd_data`. `rd_data` then holds until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, sampled on the clock edge |
| reg_idx | input | 2 | Register index for both read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe; captures a snapshot of the selected register |
| rd_data | output | 8 | Registered read result |
| rd_valid | output | 1 | One-cycle pulse marking a new read result |
| pin_in | input | 8 | Incoming pad levels (asynchronous) |
| pin_out | output | 8 | Outgoing pad values |
| pin_oe | output | 8 | Per-pad output enable, 1 = drive |

## Verification
The assertions assume that `rst_n` is low for at least two edges at start-up. This lets the synchronizer history fill before its latency check is enabled. They also assume that `wr_en`, `rd_en`, `reg_idx` and `wr_data` only change away from the rising edge. The bench drives all of these inputs at the falling edge. After a pin change it waits at least two rising edges before issuing a read, so each expected index-0 value reflects a settled synchronizer. The `pin_in` inputs are likewise changed only at falling edges, so the two-edge latency that the checker measures is exact.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int PORT_W = 8;
  localparam int IDX_W  = 2;

  typedef enum logic [IDX_W-1:0] {
    SEL_PINS  = 2'd0,
    SEL_DRIVE = 2'd1,
    SEL_INV   = 2'd2,
    SEL_DIR   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] sync_o
);
  localparam int LAST = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      chain_q <= {chain_q[STAGES-2:0], pin_i[b]};
    end
    assign sync_o[b] = chain_q[LAST];
  end

  assert_sync_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n, 2) |-> (sync_o == $past(pin_i, 2)));
endmodule

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
  import gpio_port_pkg::*;
#(
  parameter int               WIDTH     = PORT_W,
  parameter logic [WIDTH-1:0] DRIVE_RST = '0,
  parameter logic [WIDTH-1:0] INV_RST   = 8'hF0,
  parameter logic [WIDTH-1:0] DIR_RST   = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  reg_sel_e         sel,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] drive_q,
  output logic [WIDTH-1:0] inv_q,
  output logic [WIDTH-1:0] dir_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drive_q <= DRIVE_RST;
      inv_q   <= INV_RST;
      dir_q   <= DIR_RST;
    end else if (wr_en) begin
      case (sel)
        SEL_DRIVE: drive_q <= wr_data;
        SEL_INV:   inv_q   <= wr_data;
        SEL_DIR:   dir_q   <= wr_data;
        default:   ;
      endcase
    end
  end

  assert_pins_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_PINS) |=> ($stable(drive_q) && $stable(inv_q) && $stable(dir_q)));

  assert_drive_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_DRIVE) |=> (drive_q == $past(wr_data)));

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(drive_q) && $stable(inv_q) && $stable(dir_q)));

  assert_reset_defaults_R9: assert property (@(posedge clk)
    !rst_n |=> (drive_q == DRIVE_RST && inv_q == INV_RST && dir_q == DIR_RST));
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int               WIDTH   = 8,
  parameter logic [WIDTH-1:0] OD_MASK = 8'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] drive_i,
  input  logic [WIDTH-1:0] dir_i,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_pad
    if (OD_MASK[b]) begin : g_open_drain
      assign pin_out[b] = 1'b0;
      assign pin_oe[b]  = ~dir_i[b] & ~drive_i[b];
      assert_od_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        drive_i[b] |-> !pin_oe[b]);
    end else begin : g_push_pull
      assign pin_out[b] = drive_i[b];
      assign pin_oe[b]  = ~dir_i[b];
    end
  end

  assert_input_no_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & dir_i) == '0);
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int               WIDTH     = PORT_W,
  parameter logic [WIDTH-1:0] OD_MASK   = 8'h01,
  parameter logic [WIDTH-1:0] DRIVE_RST = 8'h00,
  parameter logic [WIDTH-1:0] INV_RST   = 8'hF0,
  parameter logic [WIDTH-1:0] DIR_RST   = 8'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);
  reg_sel_e         sel;
  logic [WIDTH-1:0] pins_sync;
  logic [WIDTH-1:0] drive_q, inv_q, dir_q;
  logic [WIDTH-1:0] pins_view;
  logic [WIDTH-1:0] rd_mux;

  assign sel = reg_sel_e'(reg_idx);

  gpio_in_sync #(.WIDTH(WIDTH), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_in), .sync_o(pins_sync)
  );

  gpio_reg_bank #(
    .WIDTH(WIDTH), .DRIVE_RST(DRIVE_RST), .INV_RST(INV_RST), .DIR_RST(DIR_RST)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel), .wr_data(wr_data),
    .drive_q(drive_q), .inv_q(inv_q), .dir_q(dir_q)
  );

  gpio_pad_ctrl #(.WIDTH(WIDTH), .OD_MASK(OD_MASK)) u_pads (
    .clk(clk), .rst_n(rst_n), .drive_i(drive_q), .dir_i(dir_q),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  assign pins_view = pins_sync ^ inv_q;

  always_comb begin
    case (sel)
      SEL_PINS:  rd_mux = pins_view;
      SEL_DRIVE: rd_mux = drive_q;
      SEL_INV:   rd_mux = inv_q;
      default:   rd_mux = dir_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end

  assert_rd_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  assert_rd_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/gpio_port_regs_bench.sv
module gpio_port_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // each entry: {index byte, write byte, expected read-back byte}; pins held at 0x96
  localparam logic [23:0] VECS [0:NVEC-1] = '{
    24'h01A5A5, 24'h023C3C, 24'h030F0F, 24'h0055AA, 24'h015A5A, 24'h020000
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_idx = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       rd_valid;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out;
  logic [7:0] pin_oe;

  int checks = 0;
  int failures = 0;
  logic [7:0] got;
  logic got_v;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port_regs u_gpio_port_regs (
    .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] idx, input logic [7:0] d);
    @(negedge clk);
    reg_idx = idx; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] idx);
    @(negedge clk);
    reg_idx = idx; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    got = rd_data; got_v = rd_valid;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R8 reset state
    chk("R8 oe after reset", pin_oe, 8'h00);
    rd(2'd1); chk("R8 drive default", got, 8'h00);
    rd(2'd2); chk("R8 inv default", got, 8'hF0);
    rd(2'd3); chk("R8 dir default", got, 8'hFF);

    // R1 table walk
    pin_in = 8'h96; settle();
    for (int i = 0; i < NVEC; i++) begin
      wr(VECS[i][17:16], VECS[i][15:8]);
      settle();
      rd(VECS[i][17:16]);
      chk("R1 table readback", got, VECS[i][7:0]);
    end

    // R3 input visible with pins configured as outputs
    wr(2'd3, 8'h00); wr(2'd1, 8'hC3); wr(2'd2, 8'h00);
    pin_in = 8'h3C; settle();
    rd(2'd0); chk("R3 pins while outputs", got, 8'h3C);
    // R4 drive readback is stored byte, not pin level
    rd(2'd1); chk("R4 drive not pin", got, 8'hC3);
    // R5 inversion
    wr(2'd2, 8'hFF); pin_in = 8'h0F; settle();
    rd(2'd0); chk("R5 inverted read", got, 8'hF0);
    wr(2'd2, 8'h81); settle();
    rd(2'd0); chk("R5 partial inversion", got, 8'h8E);

    // R10 valid pulse and hold
    chk("R10 valid pulse", {7'b0, got_v}, 8'h01);
    pin_in = 8'h00; settle();
    chk("R10 valid drops", {7'b0, rd_valid}, 8'h00);
    chk("R10 data holds", rd_data, 8'h8E);

    // R6 / R7 pad control
    wr(2'd3, 8'h00); wr(2'd1, 8'h00); @(negedge clk);
    chk("R7 od pull low oe", pin_oe, 8'hFF);
    chk("R7 od out zero", pin_out, 8'h00);
    wr(2'd1, 8'hFF); @(negedge clk);
    chk("R7 od release", pin_oe, 8'hFE);
    chk("R6 push-pull value", pin_out, 8'hFE);
    wr(2'd3, 8'hF0); @(negedge clk);
    chk("R6 input disables driver", pin_oe, 8'h0E);
    wr(2'd3, 8'hFE); wr(2'd1, 8'h00); @(negedge clk);
    chk("R6 only bit0 output", pin_oe, 8'h01);

    // R2 write to index 0 ignored
    wr(2'd0, 8'h77); @(negedge clk);
    chk("R2 oe unchanged", pin_oe, 8'h01);
    chk("R2 out unchanged", pin_out, 8'h00);
    rd(2'd1); chk("R2 drive unchanged", got, 8'h00);
    rd(2'd2); chk("R2 inv unchanged", got, 8'h81);
    rd(2'd3); chk("R2 dir unchanged", got, 8'hFE);

    // R9 writes ignored while reset held
    @(negedge clk); rst_n = 1'b0;
    wr(2'd1, 8'hFF); wr(2'd3, 8'h00);
    @(negedge clk);
    chk("R9 oe during reset", pin_oe, 8'h00);
    rst_n = 1'b1;
    rd(2'd1); chk("R9 drive held", got, 8'h00);
    rd(2'd2); chk("R9 inv held", got, 8'hF0);
    rd(2'd3); chk("R9 dir held", got, 8'hFF);
    wr(2'd1, 8'h3A); rd(2'd1); chk("R9 write after release", got, 8'h3A);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule